// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between the free-running source clocks of a clock generator and its output pins. It takes an asynchronous, active-low power-down request. Once the request has been confirmed, it parks every generated clock output without producing a truncated pulse. The single-ended outputs park LOW. The differential CPU pair parks with the true leg HIGH, and the complement leg's driver is released. When every output has parked, the block raises a flag that tells the oscillator and PLL they may shut down.

When the request is withdrawn, the flag drops first. The outputs then stay parked for a parameterised settle interval that stands in for PLL lock. After that interval they resume, each one on a clean rising edge.

Two mode bits from the register block decide whether the CPU true leg is also released (tri-stated) in power-down. Either bit alone is enough to select tri-state. Each output has its own stop register, and that register is clocked on the edge of its own source at which the source is already at the parked level.

Top module: `pd_sequencer`

## Requirements
- R1: The request `pd_n` is active low and asynchronous. It takes effect only when it is sampled LOW on two consecutive rising edges of `cpu_c_src`. A LOW pulse that covers only one such edge has no effect: `core_off` stays 0 and the outputs keep toggling.
- R2: After a confirmed request, each output `gclk_o[i]` parks LOW on a falling edge of its own source `src_clk[i]`. No HIGH pulse on any `gclk_o[i]` is ever shorter than the HIGH phase of its source.
- R3: During and just after reset, `core_off` is 0, `cpu_t_oe` and `cpu_c_oe` are 1, and every output follows its source.
- R4: `core_off` rises only after every output has parked, and it rises within 40 `cpu_t_src` cycles of `pd_n` going LOW. While `core_off` is 1, every `gclk_o` bit is LOW.
- R5: With both mode bits at 0, power-down holds `cpu_t_out` HIGH with `cpu_t_oe`=1, and releases the complement leg (`cpu_c_oe`=0).
- R6: If `cpu_pd_tri`=1 or `cpu_stop_tri`=1, power-down also releases the true leg (`cpu_t_oe`=0). The complement leg is still released (`cpu_c_oe`=0).
- R7: After `pd_n` returns HIGH, `core_off` falls within 5 cycles. The outputs then stay parked for at least 40 cycles (the settle interval is LOCK_CYC = 64 cycles). All outputs toggle again within LOCK_CYC+40 cycles of `core_off` falling.
- R8: A confirmed request that is withdrawn before parking has finished still completes. `core_off` rises, then falls, and the outputs restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_t_src | input | 1 | Free-running CPU true source clock |
| cpu_c_src | input | 1 | Free-running CPU complement source clock; qualifies the request |
| src_clk | input | N_CLK | Free-running single-ended source clocks |
| cpu_pd_tri | input | 1 | Mode bit: tri-state the CPU pair in power-down |
| cpu_stop_tri | input | 1 | Mode bit: force tri-state of the CPU pair, overriding cpu_pd_tri |
| gclk_o | output | N_CLK | Gated single-ended clocks |
| cpu_t_out | output | 1 | Gated CPU true clock |
| cpu_c_out | output | 1 | Gated CPU complement clock |
| cpu_t_oe | output | 1 | Driver enable for the CPU true leg |
| cpu_c_oe | output | 1 | Driver enable for the CPU complement leg |
| core_off | output | 1 | All outputs parked; core may shut down |

## Verification
Each output crosses clock domains twice on the way to `core_off`, so results are due within bounds rather than on one exact cycle. The bench therefore counts clock cycles while it waits for each edge of `core_off` and compares the count against the bounds stated in R4 and R7. Parking and restart are judged from the pin levels, which are sampled over a window at instants offset from every clock edge. Each output is also watched continuously for a HIGH pulse shorter than the HIGH phase of its source.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_STOP   = 3'd1,
    ST_OFF    = 3'd2,
    ST_LOCK   = 3'd3,
    ST_RESUME = 3'd4
  } pd_state_t;
endpackage

// File: rtl/clk_stop_cell.sv
// One output's stop register. It is clocked on the source edge at which
// the source already sits at its parked level, so the gated output can never be cut short.
module clk_stop_cell #(
  parameter bit PARK_HIGH = 1'b0
) (
  input  logic rst_n,
  input  logic src,
  input  logic stop_req,
  output logic gclk,
  output logic stopped
);
  logic rs1, rs2;
  logic sy1, sy2;

  generate
    if (PARK_HIGH) begin : g_high
      always_ff @(posedge src or negedge rst_n) begin
        if (!rst_n) begin
          rs1 <= 1'b0;
          rs2 <= 1'b0;
        end else begin
          rs1 <= 1'b1;
          rs2 <= rs1;
        end
      end
      always_ff @(posedge src or negedge rs2) begin
        if (!rs2) begin
          sy1 <= 1'b0;
          sy2 <= 1'b0;
        end else begin
          sy1 <= stop_req;
          sy2 <= sy1;
        end
      end
      assign gclk = src | sy2;
    end else begin : g_low
      always_ff @(negedge src or negedge rst_n) begin
        if (!rst_n) begin
          rs1 <= 1'b0;
          rs2 <= 1'b0;
        end else begin
          rs1 <= 1'b1;
          rs2 <= rs1;
        end
      end
      always_ff @(negedge src or negedge rs2) begin
        if (!rs2) begin
          sy1 <= 1'b0;
          sy2 <= 1'b0;
        end else begin
          sy1 <= stop_req;
          sy2 <= sy1;
        end
      end
      assign gclk = src & ~sy2;
    end
  endgenerate

  assign stopped = sy2;
endmodule

// File: rtl/pd_ctrl.sv
// Request qualifier and sequencing FSM in the CPU complement clock domain.
module pd_ctrl #(
  parameter int N_ACK    = 7,
  parameter int LOCK_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [N_ACK-1:0] stopped,
  output logic             stop_req,
  output logic             core_off
);
  import pd_pkg::*;

  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_CYC - 1);

  logic             rs1, rs2;
  logic             pd_s1, pd_s2;
  logic [N_ACK-1:0] ack_s1, ack_s2;
  pd_state_t        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;
  logic             pd_low, pd_high, all_stopped, all_running;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end

  always_ff @(posedge clk or negedge rs2) begin
    if (!rs2) begin
      pd_s1  <= 1'b1;
      pd_s2  <= 1'b1;
      ack_s1 <= '0;
      ack_s2 <= '0;
    end else begin
      pd_s1  <= pd_n;
      pd_s2  <= pd_s1;
      ack_s1 <= stopped;
      ack_s2 <= ack_s1;
    end
  end

  assign pd_low      = !pd_s1 && !pd_s2;
  assign pd_high     = pd_s1 && pd_s2;
  assign all_stopped = &ack_s2;
  assign all_running = ~|ack_s2;

  always_comb begin
    state_d = state_q;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    case (state_q)
      ST_RUN:    if (pd_low) state_d = ST_STOP;
      ST_STOP:   if (all_stopped) state_d = ST_OFF;
      ST_OFF:    if (pd_high) begin
                   state_d = ST_LOCK;
                   cnt_en  = 1'b1;
                   cnt_d   = '0;
                 end
      ST_LOCK:   begin
                   cnt_en = 1'b1;
                   cnt_d  = cnt_q + 1'b1;
                   if (cnt_q == CNT_LAST) state_d = ST_RESUME;
                 end
      ST_RESUME: if (all_running) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rs2) begin
    if (!rs2) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign stop_req = (state_q == ST_STOP) || (state_q == ST_OFF) || (state_q == ST_LOCK);
  assign core_off = (state_q == ST_OFF);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
  parameter int N_CLK    = 5,
  parameter int LOCK_CYC = 64
) (
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             cpu_t_src,
  input  logic             cpu_c_src,
  input  logic [N_CLK-1:0] src_clk,
  input  logic             cpu_pd_tri,
  input  logic             cpu_stop_tri,
  output logic [N_CLK-1:0] gclk_o,
  output logic             cpu_t_out,
  output logic             cpu_c_out,
  output logic             cpu_t_oe,
  output logic             cpu_c_oe,
  output logic             core_off
);
  localparam int N_ACK = N_CLK + 2;

  logic             stop_req;
  logic [N_ACK-1:0] stopped;

  pd_ctrl #(.N_ACK(N_ACK), .LOCK_CYC(LOCK_CYC)) u_ctrl (
    .clk      (cpu_c_src),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .stopped  (stopped),
    .stop_req (stop_req),
    .core_off (core_off)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_CLK; gi++) begin : g_out
      clk_stop_cell #(.PARK_HIGH(1'b0)) u_cell (
        .rst_n    (rst_n),
        .src      (src_clk[gi]),
        .stop_req (stop_req),
        .gclk     (gclk_o[gi]),
        .stopped  (stopped[gi])
      );
    end
  endgenerate

  clk_stop_cell #(.PARK_HIGH(1'b1)) u_cpu_t (
    .rst_n    (rst_n),
    .src      (cpu_t_src),
    .stop_req (stop_req),
    .gclk     (cpu_t_out),
    .stopped  (stopped[N_CLK])
  );

  clk_stop_cell #(.PARK_HIGH(1'b0)) u_cpu_c (
    .rst_n    (rst_n),
    .src      (cpu_c_src),
    .stop_req (stop_req),
    .gclk     (cpu_c_out),
    .stopped  (stopped[N_CLK+1])
  );

  // either mode bit releases the true leg once it is parked
  assign cpu_t_oe = !(stopped[N_CLK] && (cpu_pd_tri || cpu_stop_tri));
  assign cpu_c_oe = !stopped[N_CLK+1];
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter int N_CLK = 5
) (
  input logic             rst_n,
  input logic             cpu_c_src,
  input logic             cpu_pd_tri,
  input logic             cpu_stop_tri,
  input logic [N_CLK-1:0] gclk_o,
  input logic             cpu_t_out,
  input logic             cpu_t_oe,
  input logic             cpu_c_oe,
  input logic             core_off
);
  p_off_all_low_r4: assert property (@(posedge cpu_c_src) disable iff (!rst_n)
    core_off |-> (gclk_o == '0));

  p_true_high_r5: assert property (@(posedge cpu_c_src) disable iff (!rst_n)
    core_off |-> cpu_t_out);

  p_comp_undriven_r5: assert property (@(posedge cpu_c_src) disable iff (!rst_n)
    core_off |-> !cpu_c_oe);

  p_default_drive_r5: assert property (@(posedge cpu_c_src) disable iff (!rst_n)
    (core_off && !cpu_pd_tri && !cpu_stop_tri) |-> cpu_t_oe);

  p_tri_mode_r6: assert property (@(posedge cpu_c_src) disable iff (!rst_n)
    (core_off && (cpu_pd_tri || cpu_stop_tri)) |-> !cpu_t_oe);
endmodule

bind pd_sequencer pd_sequencer_chk #(.N_CLK(N_CLK)) u_chk (
  .rst_n        (rst_n),
  .cpu_c_src    (cpu_c_src),
  .cpu_pd_tri   (cpu_pd_tri),
  .cpu_stop_tri (cpu_stop_tri),
  .gclk_o       (gclk_o),
  .cpu_t_out    (cpu_t_out),
  .cpu_t_oe     (cpu_t_oe),
  .cpu_c_oe     (cpu_c_oe),
  .core_off     (core_off)
);

// File: tb/tb_pd_sequencer.sv
`timescale 1ns/100ps
module tb_pd_sequencer;
  localparam int N_CLK    = 5;
  localparam int LOCK_CYC = 64;
  localparam int HP [N_CLK] = '{15, 20, 30, 25, 35};
  // vector: {cpu_pd_tri, cpu_stop_tri, expected cpu_t_oe while off}
  localparam logic [2:0] VEC [4] = '{3'b001, 3'b100, 3'b010, 3'b110};

  logic clk = 1'b0;
  logic rst_n, pd_n, cpu_pd_tri, cpu_stop_tri;
  logic [N_CLK-1:0] src_clk, gclk_o, runt_vec;
  logic cpu_t_out, cpu_c_out, cpu_t_oe, cpu_c_oe, core_off;
  logic mon_en = 1'b0;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  genvar g;
  generate
    for (g = 0; g < N_CLK; g++) begin : g_src
      logic s = 1'b0;
      real t_rise = -1.0;
      int  runts = 0;
      always #(HP[g]) s = ~s;
      assign src_clk[g] = s;
      always @(posedge gclk_o[g]) t_rise = $realtime;
      always @(negedge gclk_o[g])
        if (mon_en && t_rise >= 0.0 && ($realtime - t_rise) < (HP[g] - 0.5)) runts++;
      assign runt_vec[g] = (runts != 0);
    end
  endgenerate

  pd_sequencer #(.N_CLK(N_CLK), .LOCK_CYC(LOCK_CYC)) dut (
    .rst_n(rst_n), .pd_n(pd_n), .cpu_t_src(clk), .cpu_c_src(~clk),
    .src_clk(src_clk), .cpu_pd_tri(cpu_pd_tri), .cpu_stop_tri(cpu_stop_tri),
    .gclk_o(gclk_o), .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out),
    .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe), .core_off(core_off)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample levels at instants offset from all clock edges
  task automatic scan(input int n, output logic [N_CLK-1:0] seen0, output logic [N_CLK-1:0] seen1);
    seen0 = '0; seen1 = '0;
    for (int k = 0; k < n; k++) begin
      #7.3;
      seen0 |= ~gclk_o;
      seen1 |= gclk_o;
    end
  endtask

  task automatic wait_core(input logic lvl, input int lim, output int n);
    n = 0;
    while (core_off != lvl && n < lim) begin
      @(posedge clk);
      n++;
    end
    #3;
  endtask

  task automatic pd_cycle(input string rq, input logic [2:0] v);
    logic [N_CLK-1:0] s0, s1;
    int n;
    cpu_pd_tri = v[2]; cpu_stop_tri = v[1];
    @(posedge clk); #4;
    pd_n = 1'b0;
    wait_core(1'b1, 60, n);
    check("R4 core_off latency bound", int'(n <= 40), 1);
    scan(40, s0, s1);
    check("R4 outputs parked low", int'(s1), 0);
    check("R5 cpu_t held high", int'(cpu_t_out), 1);
    check({rq, " cpu_t_oe in power-down"}, int'(cpu_t_oe), int'(v[0]));
    check("R5 cpu_c released", int'(cpu_c_oe), 0);
    pd_n = 1'b1;
    wait_core(1'b0, 20, n);
    check("R7 core_off falls after release", int'(n <= 5), 1);
    scan(100, s0, s1);
    check("R7 parked during settle", int'(s1), 0);
    repeat (LOCK_CYC + 40 - 37) @(posedge clk);
    #3;
    scan(140, s0, s1);
    check("R7 all outputs restarted", int'(s0 & s1), (1 << N_CLK) - 1);
    check("R7 cpu_c_oe restored", int'(cpu_c_oe), 1);
    check("R2 no runt pulse", int'(runt_vec), 0);
  endtask

  initial begin
    logic [N_CLK-1:0] s0, s1;
    int n;
    rst_n = 1'b0; pd_n = 1'b1; cpu_pd_tri = 1'b0; cpu_stop_tri = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    check("R3 core_off in reset", int'(core_off), 0);
    check("R3 cpu_t_oe in reset", int'(cpu_t_oe), 1);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #3;
    mon_en = 1'b1;
    scan(140, s0, s1);
    check("R3 outputs follow sources", int'(s0 & s1), (1 << N_CLK) - 1);
    check("R3 cpu_c_oe after reset", int'(cpu_c_oe), 1);

    // R5 default mode and R6 tri-state modes, from the vector table
    for (int i = 0; i < 4; i++)
      pd_cycle((VEC[i][2] | VEC[i][1]) ? "R6" : "R5", VEC[i]);

    // R1: a LOW pulse covering a single complement rising edge is ignored
    cpu_pd_tri = 1'b0; cpu_stop_tri = 1'b0;
    @(posedge clk); #5;
    pd_n = 1'b0;
    #10;
    pd_n = 1'b1;
    repeat (30) @(posedge clk);
    #3;
    check("R1 single-sample glitch ignored", int'(core_off), 0);
    scan(140, s0, s1);
    check("R1 outputs still toggling", int'(s0 & s1), (1 << N_CLK) - 1);

    // R8: request withdrawn right after qualification still completes
    @(posedge clk); #4;
    pd_n = 1'b0;
    repeat (3) @(posedge clk);
    pd_n = 1'b1;
    wait_core(1'b1, 60, n);
    check("R8 core_off reached after early release", int'(core_off), 1);
    wait_core(1'b0, 20, n);
    check("R8 core_off falls", int'(core_off), 0);
    repeat (LOCK_CYC + 40) @(posedge clk);
    #3;
    scan(140, s0, s1);
    check("R8 outputs restarted", int'(s0 & s1), (1 << N_CLK) - 1);
    check("R2 no runt pulse overall", int'(runt_vec), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule